// File: doc/BRIEF.md
# Periodic Down-Count Interrupt Timer

This block is a 16-bit down-counter that raises a periodic interrupt. Software programs it through three registers on a small register bus: a control/status word, a modulus, and a read-only view of the live count. A 4-bit divide field sets how often the counter steps. Each step happens once every 2^div clock cycles, so the divide ratio runs from 1 to 32768.

In reload mode the counter starts from the modulus, and after reaching zero it starts over from the modulus. In free-running mode it starts from 0xFFFF and ignores the modulus. Every expiry sets a sticky event flag. The interrupt line is high while that flag is set and enabled.

Software clears the flag by writing a one to its bit. A write that only toggles the interrupt enable, or only clears the flag, leaves the count running undisturbed. Any other change to the control word re-arms the counter. A modulus write can also replace the running count at once.

Top module: `intv_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF and `irq` is low.
- R2: While the enable bit (bit 0) is set, the count drops by one every 2^div clock cycles, where div is control bits 11:8. The first step comes 2^div cycles after the write that armed the counter.
- R3: With the reload bit (bit 1) set, the counter starts from the modulus. On a step taken at zero it reloads the modulus and sets the event flag in the same cycle.
- R4: With the reload bit clear, the counter starts from 0xFFFF and reloads 0xFFFF whatever the modulus holds. The event flag is set when it steps past zero.
- R5: The event flag (bit 2) is set only by an expiry. Writing 1 to bit 2 clears the flag, and writing 0 to bit 2 leaves it unchanged.
- R6: `irq` is high exactly when the event flag and the interrupt enable (bit 3) are both set.
- R7: A write to the modulus (offset 2) clears the event flag. If the overwrite bit (bit 4) is set, the written value becomes the count in the next cycle, and the divider restarts.
- R8: A modulus write with the overwrite bit clear leaves the running count alone. In reload mode the new value is used at the next reload.
- R9: A control write that differs from the stored word only in bit 3 and/or bit 2 does not reload, stop or re-time the counter.
- R10: Any other control write loads the count with the reload value selected by the new reload bit and restarts the divider. If the new enable bit is clear, the count then holds.
- R11: Reads return the control word at offset 0, the modulus at offset 2 and the live count at offset 4. Reads at any other offset return zero, and writes to offset 4 have no effect.
- R12: Bits 5 and 6 of the control word are stored and read back but do not change counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational while a read is strobed, else zero |
| irq | output | 1 | Level interrupt request |

## Verification
The count is swept cycle by cycle across every divide setting from 0 to 3 and several modulus values, including zero. The bench predicts each reading as modulus minus (ticks mod (modulus+1)). These sweeps separate an off-by-one in the divider from one in the reload point or in the moment the flag is set. A free-running run with a small modulus programmed, stepped through a full 65536-tick wrap, shows that the modulus is ignored in that mode. A single tick at the largest divide checks the widest mask. Separate sequences interleave interrupt-enable-only writes, flag clears and modulus writes with and without overwrite against a running count. They tell a write that must leave the count alone apart from one that must re-arm it.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

    localparam int DATA_W = 16;
    localparam int DIV_W  = 4;

    // Control word bit positions (software-visible layout)
    localparam int BIT_EN   = 0;
    localparam int BIT_RLD  = 1;
    localparam int BIT_FLAG = 2;
    localparam int BIT_IE   = 3;
    localparam int BIT_OVW  = 4;
    localparam int BIT_DBG  = 5;
    localparam int BIT_DOZE = 6;
    localparam int DIV_LSB  = 8;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             rld;
        logic             en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MOD  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en   = w[BIT_EN];
        c.rld  = w[BIT_RLD];
        c.ie   = w[BIT_IE];
        c.ovw  = w[BIT_OVW];
        c.dbg  = w[BIT_DBG];
        c.doze = w[BIT_DOZE];
        c.div  = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c, input logic flag);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_EN]   = c.en;
        w[BIT_RLD]  = c.rld;
        w[BIT_FLAG] = flag;
        w[BIT_IE]   = c.ie;
        w[BIT_OVW]  = c.ovw;
        w[BIT_DBG]  = c.dbg;
        w[BIT_DOZE] = c.doze;
        w[DIV_LSB +: DIV_W] = c.div;
        return w;
    endfunction

    function automatic ctrl_t drop_ie(input ctrl_t c);
        ctrl_t r;
        r    = c;
        r.ie = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/intv_timer_regs.sv
module intv_timer_regs
    import intv_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag_set,
    input  logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic              flag,
    output logic [CNT_W-1:0]  modulus,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    sel_e  sel;
    ctrl_t wr_c;
    logic  wr_ctrl, wr_mod, ie_only, reprog, ovr_load;
    logic  [DATA_W-1:0] mod_ext, cnt_ext;
    logic  wd_unused;

    always_comb begin
        case (bus_addr)
            ADDR_W'(0): sel = SEL_CTRL;
            ADDR_W'(2): sel = SEL_MOD;
            ADDR_W'(4): sel = SEL_CNT;
            default:    sel = SEL_NONE;
        endcase
    end

    assign wr_ctrl  = bus_valid && bus_write && (sel == SEL_CTRL);
    assign wr_mod   = bus_valid && bus_write && (sel == SEL_MOD);
    assign wr_c     = ctrl_from_word(bus_wdata);
    assign ie_only  = (drop_ie(wr_c) == drop_ie(ctrl));
    assign reprog   = wr_ctrl && !ie_only;
    assign ovr_load = wr_mod && ctrl.ovw;
    assign load     = reprog || ovr_load;
    assign load_val = reprog ? (wr_c.rld ? modulus : ALL_ONES) : bus_wdata[CNT_W-1:0];

    // Reserved write-data bits are deliberately dropped
    assign wd_unused = ^{bus_wdata[7], bus_wdata[DATA_W-1:DIV_LSB+DIV_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            modulus <= ALL_ONES;
            flag    <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= wr_c;
            if (wr_mod)
                modulus <= bus_wdata[CNT_W-1:0];
            if (flag_set)
                flag <= 1'b1;
            else if (wr_mod || (wr_ctrl && bus_wdata[BIT_FLAG]))
                flag <= 1'b0;
        end
    end

    always_comb begin
        mod_ext = '0;
        mod_ext[CNT_W-1:0] = modulus;
        cnt_ext = '0;
        cnt_ext[CNT_W-1:0] = count;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (sel)
                SEL_CTRL: bus_rdata = ctrl_to_word(ctrl, flag);
                SEL_MOD:  bus_rdata = mod_ext;
                SEL_CNT:  bus_rdata = cnt_ext;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/intv_timer_prescale.sv
module intv_timer_prescale #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int PSC_W = (1 << DIV_W) - 1;

    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] mask;

    assign mask = ~({PSC_W{1'b1}} << div);
    assign tick = run && ((psc_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            psc_q <= '0;
        else
            psc_q <= psc_q + 1'b1;
    end

endmodule

// File: rtl/intv_timer_counter.sv
module intv_timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic at_zero;

    assign at_zero = (count == '0);
    assign expire  = tick && !load && at_zero;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '1;
        else if (load)
            count <= load_val;
        else if (tick)
            count <= at_zero ? reload_val : count - 1'b1;
    end

endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import intv_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq
);

    localparam logic [CNT_W-1:0] FREE_TOP = '1;

    ctrl_t            ctrl_q;
    logic             flag_q, psc_tick, cnt_load, cnt_expire;
    logic [CNT_W-1:0] modulus_q, load_val, count_q, reload_val;

    assign reload_val = ctrl_q.rld ? modulus_q : FREE_TOP;
    assign irq        = ctrl_q.ie && flag_q;

    intv_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag_set  (cnt_expire),
        .count     (count_q),
        .ctrl      (ctrl_q),
        .flag      (flag_q),
        .modulus   (modulus_q),
        .load      (cnt_load),
        .load_val  (load_val),
        .bus_rdata (bus_rdata)
    );

    intv_timer_prescale #(.DIV_W(DIV_W)) psc_i (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.en),
        .restart (cnt_load),
        .div     (ctrl_q.div),
        .tick    (psc_tick)
    );

    intv_timer_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (psc_tick),
        .load       (cnt_load),
        .load_val   (load_val),
        .reload_val (reload_val),
        .count      (count_q),
        .expire     (cnt_expire)
    );

endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              irq,
    input logic              tick,
    input logic              load,
    input logic [CNT_W-1:0]  count,
    input logic              flag,
    input logic              ovw
);

    logic mod_wr;
    assign mod_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(2));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && count != '0) |=> (count == $past(count) - 1'b1));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));

    p_expire_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && count == '0) |=> flag);

    p_flag_source_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick && !load && count == '0));

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !flag |-> !irq);

    p_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
        (mod_wr && ovw) |=> (count == $past(bus_wdata[CNT_W-1:0])));

    p_mod_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (mod_wr && !(tick && count == '0)) |=> !flag);

endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .tick      (psc_tick),
    .load      (cnt_load),
    .count     (count_q),
    .flag      (flag_q),
    .ovw       (ctrl_q.ovw)
);

// File: tb/intv_timer_tb_top.sv
`timescale 1ns/1ps
module intv_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bv = 1'b0, bw = 1'b0;
    logic [3:0]  ba = '0;
    logic [15:0] bd = '0;
    logic [15:0] rdata;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    intv_timer dut_i (
        .clk(clk), .rst(rst), .bus_valid(bv), .bus_write(bw),
        .bus_addr(ba), .bus_wdata(bd), .bus_rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bv = 1'b1; bw = 1'b1; ba = a; bd = d;
        @(posedge clk);
        @(negedge clk);
        bv = 1'b0; bw = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bv = 1'b1; bw = 1'b0; ba = a;
        #0.5;
        d = rdata;
        bv = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] cw(input int en, input int rld, input int ie,
                                       input int ovw, input int div);
        return 16'((en & 1) | ((rld & 1) << 1) | ((ie & 1) << 3) |
                   ((ovw & 1) << 4) | ((div & 15) << 8));
    endfunction

    // reload-mode sweep: count = r - (k mod (r+1)), k = m >> div
    task automatic sweep(input int div, input int r, input logic [15:0] extra);
        logic [15:0] v, cfg;
        int k, m_end;
        wr(0, 16'h0004);
        wr(2, 16'(r));
        cfg = cw(1, 1, 0, 0, div) | extra;
        wr(0, cfg);
        m_end = (r + 1) * (1 << div) * 2 + 3;
        for (int m = 0; m <= m_end; m++) begin
            k = m >> div;
            rd(4, v);
            check("R2/R3 count", v, 32'(r - (k % (r + 1))));
            rd(0, v);
            check("R3/R12 ctrl readback", v, cfg | ((k >= r + 1) ? 16'h0004 : 16'h0000));
            check("R6 irq masked", irq, 0);
            step(1);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(0, v); check("R1 ctrl", v, 16'h0000);
        rd(2, v); check("R1 modulus", v, 16'hFFFF);
        rd(4, v); check("R1 count", v, 16'hFFFF);
        check("R1 irq", irq, 0);
        step(3);
        rd(4, v); check("R1 count idle", v, 16'hFFFF);

        // R2 R3 R12: reload sweeps over divide 0..3 and several moduli
        for (int d = 0; d < 4; d++) begin
            sweep(d, 0, 16'h0000);
            sweep(d, 1, 16'h0000);
            sweep(d, 3, 16'h0000);
            sweep(d, 6, 16'h0000);
        end
        sweep(1, 2, 16'h0060); // R12 debug/doze bits set

        // R11 unmapped reads
        rd(6, v); check("R11 unmapped 6", v, 16'h0000);
        rd(8, v); check("R11 unmapped 8", v, 16'h0000);
        rd(15, v); check("R11 unmapped 15", v, 16'h0000);

        // R5 R6 R9: flag handling with enable toggles, period 4
        wr(0, 16'h0004); wr(2, 16'd3); wr(0, cw(1, 1, 0, 0, 0));  // m=0
        step(5);                                                    // m=5
        rd(0, v); check("R5 flag set by expiry", v[2], 1);
        check("R6 irq off when disabled", irq, 0);
        rd(4, v); check("R9 count m5", v, 16'd2);
        wr(0, cw(1, 1, 1, 0, 0));                                   // m=6, ie only, flag bit 0
        rd(0, v); check("R5 write 0 keeps flag", v[2], 1);
        check("R6 irq high", irq, 1);
        rd(4, v); check("R9 ie write keeps count", v, 16'd1);
        wr(0, cw(1, 1, 1, 0, 0) | 16'h0004);                         // m=7, flag clear
        rd(0, v); check("R5 w1c clears", v[2], 0);
        check("R6 irq low after clear", irq, 0);
        rd(4, v); check("R9 clear write keeps count", v, 16'd0);
        step(1);                                                    // m=8
        rd(0, v); check("R3 flag again", v[2], 1);
        check("R6 irq again", irq, 1);
        rd(4, v); check("R3 reload", v, 16'd3);

        // R7 R8: modulus writes without overwrite
        wr(0, 16'h0004); wr(2, 16'd9); wr(0, cw(1, 1, 0, 0, 0));  // m=0, count 9
        step(2);                                                    // m=2
        wr(2, 16'd4);                                               // m=3
        rd(4, v); check("R8 count unaffected", v, 16'd6);
        rd(2, v); check("R11 modulus readback", v, 16'd4);
        step(7);                                                    // m=10
        rd(4, v); check("R8 new modulus at reload", v, 16'd4);
        rd(0, v); check("R3 flag at reload", v[2], 1);
        wr(2, 16'd4);                                               // m=11
        rd(0, v); check("R7 modulus write clears flag", v[2], 0);
        rd(4, v); check("R8 count continues", v, 16'd3);

        // R7 overwrite
        wr(0, cw(1, 1, 0, 1, 1));                                   // count 4, div 1
        step(3);
        rd(4, v); check("R2 div1 step", v, 16'd3);
        wr(2, 16'd20);
        rd(4, v); check("R7 overwrite loads", v, 16'd20);
        step(1);
        rd(4, v); check("R7 divider restarted", v, 16'd20);
        step(1);
        rd(4, v); check("R7 first step after load", v, 16'd19);

        // R10 enable clear: count loads and holds
        wr(0, cw(0, 1, 0, 0, 0));
        rd(4, v); check("R10 load on disable", v, 16'd20);
        step(10);
        rd(4, v); check("R10 hold", v, 16'd20);
        wr(0, cw(0, 0, 0, 0, 2));
        rd(4, v); check("R10 reprogram loads 0xFFFF", v, 16'hFFFF);

        // R4 free-running, R11 counter write ignored
        wr(0, 16'h0004); wr(2, 16'd5); wr(0, cw(1, 0, 0, 0, 0));   // m=0
        for (int m = 0; m <= 20; m++) begin
            rd(4, v); check("R4 free count", v, 16'(16'hFFFF - m));
            step(1);
        end                                                         // m=21
        wr(4, 16'h1234);                                            // m=22
        rd(4, v); check("R11 counter write ignored", v, 16'(16'hFFFF - 22));
        rd(0, v); check("R4 no early flag", v[2], 0);
        step(65536 - 22 - 1);                                       // m=65535
        rd(4, v); check("R4 at zero", v, 16'h0000);
        rd(0, v); check("R4 flag clear at zero", v[2], 0);
        step(1);                                                    // m=65536
        rd(4, v); check("R4 reloads 0xFFFF", v, 16'hFFFF);
        rd(0, v); check("R4 flag on wrap", v[2], 1);

        // R2 widest divide
        wr(0, 16'h0004); wr(2, 16'd2); wr(0, cw(1, 1, 0, 0, 15));
        step(32767);
        rd(4, v); check("R2 div15 before tick", v, 16'd2);
        step(1);
        rd(4, v); check("R2 div15 tick", v, 16'd1);

        done = 1'b1;
        finish_run();
    end

endmodule